// File: doc/BRIEF.md
# Programmable Parallel Bus Strobe Timer

This block sequences one access on an 8080-style parallel display bus. When an access request arrives while the block is idle, it latches the requested direction and address/command level, along with the chip select chosen by a 2-bit target field. It then runs a tick counter through one bus cycle. The chip-select, write, read and address/command strobes switch at tick positions taken from two timing words per chip select.

The first word holds the on and off ticks of each strobe. The second holds:
- the write and read cycle lengths,
- an optional chip-select pulse-width limit,
- the tick at which read data is to be captured.

A granularity bit per chip select stretches every tick to two clocks. A polarity nibble per chip select sets the active sense of each pin. A window whose off tick does not lie after its on tick is reported on an error output, and that strobe stays inactive.

A request is answered with a `busy` interval and then a one-clock `done` pulse. During read accesses, a one-clock `rd_capture` pulse tells the surrounding logic when to sample the bus.

Top module: `pbus_strobe_timer`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `rd_capture` are 0, every strobe pin sits at its inactive level, and the address/command pin shows logic 0 through its polarity.
- R2: A request is accepted only when `req_valid` is high, the block is idle, and `cs_sel` is 1 (chip select 0) or 2 (chip select 1). When `cs_sel` is 0 or 3, the request is ignored. A request made while `busy` is high is dropped and not queued.
- R3: `busy` rises in the clock after acceptance and stays high for C ticks. C is the write cycle field (cycle word bits 5:0) for writes and the read cycle field (bits 11:6) for reads, and a value of 0 counts as 1. A tick lasts one clock, or two clocks when the target's `tick_x2` bit is set.
- R4: `done` is high for exactly the one clock that follows the last `busy` clock.
- R5: With the tick count t starting at 0, a strobe is active in tick t when on <= t < off. The on/off word holds, from bit 0 upward: chip-select on (4 bits), chip-select off (6), write on (4), write off (6), read on (4), read off (6).
- R6: When the chip-select pulse-width field (cycle word bits 17:12) is nonzero and on+width < off, the chip select goes inactive at tick on+width instead of at off.
- R7: Only the target's chip-select pin moves during an access. The write strobe is active only in writes and the read strobe only in reads.
- R8: In a read access, `rd_capture` is high for one clock: the first clock of the tick that equals the access field (cycle word bits 27:22). It never pulses in writes, or when that tick is not reached.
- R9: Polarity nibble: bit 3 chip select, bit 2 write, bit 1 read, bit 0 address/command. For a strobe, 0 means active low and 1 means active high. For the address/command pin, 0 drives the latched value and 1 drives its inverse. When idle, the address/command level is logic 0 through the polarity. The write, read and address/command pins use the nibble of the last accepted target (chip select 0 after reset).
- R10: `cfg_err` bit 0 (chip select), bit 1 (write) and bit 2 (read) are set when that strobe's off field is not greater than its on field. These bits use the timing word of the chip select named by `cs_sel` (chip select 1 when `cs_sel` is 2, otherwise chip select 0). A flagged strobe stays inactive for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_sel | input | 2 | Target chip select: 1 selects CS0, 2 selects CS1, 0 and 3 select none |
| tim_onoff | input | 2x30 | Per chip select on/off tick word |
| tim_cycle | input | 2x28 | Per chip select cycle word |
| tick_x2 | input | 2 | Per chip select tick-doubling bit |
| pol | input | 2x4 | Per chip select polarity nibble |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 write, 0 read |
| req_a0 | input | 1 | Address/command level for the access |
| busy | output | 1 | Access in progress |
| cs_pin | output | 2 | Chip-select pins |
| we_pin | output | 1 | Write strobe pin |
| re_pin | output | 1 | Read strobe pin |
| a0_pin | output | 1 | Address/command pin |
| rd_capture | output | 1 | Read data capture pulse |
| done | output | 1 | End-of-access pulse |
| cfg_err | output | 3 | Inverted-window flags for the selected timing word |

## Verification
Directed accesses place each window in a known position. A plain write window tells on/off decoding apart from off-by-one errors. A doubled-tick read separates tick length from cycle length and places the capture pulse. A pulse-width-limited chip select and a zero cycle length cover the clipping rule and the minimum-length rule. An inverted window and an all-ones polarity setting exercise the error path and pin inversion. Requests with no target, and requests made during an access, must leave `busy` untouched. Random timing words, targets, directions and polarities from a fixed seed are then checked clock by clock against a bench model of every pin.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int NCS      = 2;
    localparam int ON_W     = 4;
    localparam int OFF_W    = 6;
    localparam int TICK_W   = 6;
    localparam int ONOFF_W  = 3 * (ON_W + OFF_W);
    localparam int CYCLE_W  = 28;
    localparam int POL_W    = 4;
    localparam int NSTROBE  = 3;

    localparam logic [1:0] SEL_CS0 = 2'd1;
    localparam logic [1:0] SEL_CS1 = 2'd2;

    // on/off word, first field at bit 0
    typedef struct packed {
        logic [OFF_W-1:0] re_off;
        logic [ON_W-1:0]  re_on;
        logic [OFF_W-1:0] we_off;
        logic [ON_W-1:0]  we_on;
        logic [OFF_W-1:0] cs_off;
        logic [ON_W-1:0]  cs_on;
    } onoff_t;

    typedef struct packed {
        logic [TICK_W-1:0] acc;
        logic [3:0]        rsv;
        logic [TICK_W-1:0] cs_pw;
        logic [TICK_W-1:0] rd_cyc;
        logic [TICK_W-1:0] wr_cyc;
    } cycle_t;

    typedef struct packed {
        logic cs;
        logic we;
        logic re;
        logic a0;
    } pol_t;

    typedef enum logic [1:0] {
        STB_CS = 2'd0,
        STB_WE = 2'd1,
        STB_RE = 2'd2
    } strobe_e;

    // chip-select stop tick with optional pulse-width clip
    function automatic logic [OFF_W-1:0] cs_stop(
        input logic [ON_W-1:0]   on,
        input logic [OFF_W-1:0]  off,
        input logic [TICK_W-1:0] pw
    );
        logic [OFF_W:0] sum;
        sum = {{(OFF_W+1-ON_W){1'b0}}, on} + {1'b0, pw};
        if (pw != '0 && sum < {1'b0, off})
            return sum[OFF_W-1:0];
        return off;
    endfunction

    function automatic logic window_bad(
        input logic [ON_W-1:0]  on,
        input logic [OFF_W-1:0] off
    );
        return off <= {{(OFF_W-ON_W){1'b0}}, on};
    endfunction

    function automatic logic [NSTROBE-1:0] err_flags(input onoff_t w);
        logic [NSTROBE-1:0] e;
        e[STB_CS] = window_bad(w.cs_on, w.cs_off);
        e[STB_WE] = window_bad(w.we_on, w.we_off);
        e[STB_RE] = window_bad(w.re_on, w.re_off);
        return e;
    endfunction

    // a zero cycle length runs as one tick
    function automatic logic [TICK_W:0] eff_len(input logic [TICK_W-1:0] c);
        return (c == '0) ? (TICK_W+1)'(1) : {1'b0, c};
    endfunction

endpackage

// File: rtl/pbus_window.sv
module pbus_window #(
    parameter int ON_W  = 4,
    parameter int OFF_W = 6,
    parameter int T_W   = 6
) (
    input  logic             en,
    input  logic [ON_W-1:0]  on,
    input  logic [OFF_W-1:0] off,
    input  logic [T_W-1:0]   tick,
    output logic             active
);
    localparam int CMP_W = (OFF_W > T_W) ? OFF_W : T_W;

    logic [CMP_W-1:0] on_x, off_x, t_x;

    always_comb begin
        on_x   = CMP_W'(on);
        off_x  = CMP_W'(off);
        t_x    = CMP_W'(tick);
        active = en && (off_x > on_x) && (t_x >= on_x) && (t_x < off_x);
    end
endmodule

// File: rtl/pbus_tick_seq.sv
module pbus_tick_seq #(
    parameter int T_W = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           x2,
    input  logic [T_W:0]   len,
    output logic           busy,
    output logic [T_W-1:0] tick,
    output logic           first,
    output logic           done
);
    logic sub_q;
    logic last_tick;

    assign last_tick = ({1'b0, tick} + (T_W+1)'(1)) == len;
    assign first     = !sub_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            tick  <= '0;
            sub_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    tick  <= '0;
                    sub_q <= 1'b0;
                end
            end else if (x2 && !sub_q) begin
                sub_q <= 1'b1;
            end else begin
                sub_q <= 1'b0;
                if (last_tick) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    tick <= '0;
                end else begin
                    tick <= tick + T_W'(1);
                end
            end
        end
    end

    // R3
    tick_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> ({1'b0, tick} < len));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/pbus_strobe_timer.sv
module pbus_strobe_timer
    import pbus_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [1:0]                     cs_sel,
    input  logic [NCS-1:0][ONOFF_W-1:0]    tim_onoff,
    input  logic [NCS-1:0][CYCLE_W-1:0]    tim_cycle,
    input  logic [NCS-1:0]                 tick_x2,
    input  logic [NCS-1:0][POL_W-1:0]      pol,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic                           req_a0,
    output logic                           busy,
    output logic [NCS-1:0]                 cs_pin,
    output logic                           we_pin,
    output logic                           re_pin,
    output logic                           a0_pin,
    output logic                           rd_capture,
    output logic                           done,
    output logic [NSTROBE-1:0]             cfg_err
);
    logic              tgt_q, wr_q, a0_q;
    logic              accept;
    logic              first_w;
    logic [TICK_W-1:0] tick_w;
    logic [TICK_W:0]   len_w;
    onoff_t            on_cfg;
    cycle_t            cy_cfg;
    pol_t              pol_cfg;
    logic              unused_rsv;

    logic [NSTROBE-1:0]            stb_en;
    logic [NSTROBE-1:0][ON_W-1:0]  stb_on;
    logic [NSTROBE-1:0][OFF_W-1:0] stb_off;
    logic [NSTROBE-1:0]            stb_act;

    assign accept = req_valid && !busy && (cs_sel == SEL_CS0 || cs_sel == SEL_CS1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= 1'b0;
            wr_q  <= 1'b0;
            a0_q  <= 1'b0;
        end else if (accept) begin
            tgt_q <= (cs_sel == SEL_CS1);
            wr_q  <= req_write;
            a0_q  <= req_a0;
        end
    end

    assign on_cfg     = onoff_t'(tim_onoff[tgt_q]);
    assign cy_cfg     = cycle_t'(tim_cycle[tgt_q]);
    assign pol_cfg    = pol_t'(pol[tgt_q]);
    assign unused_rsv = ^cy_cfg.rsv;
    assign len_w      = eff_len(wr_q ? cy_cfg.wr_cyc : cy_cfg.rd_cyc);

    pbus_tick_seq #(.T_W(TICK_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .x2    (tick_x2[tgt_q]),
        .len   (len_w),
        .busy  (busy),
        .tick  (tick_w),
        .first (first_w),
        .done  (done)
    );

    always_comb begin
        stb_on[STB_CS]  = on_cfg.cs_on;
        stb_off[STB_CS] = cs_stop(on_cfg.cs_on, on_cfg.cs_off, cy_cfg.cs_pw);
        stb_en[STB_CS]  = busy;
        stb_on[STB_WE]  = on_cfg.we_on;
        stb_off[STB_WE] = on_cfg.we_off;
        stb_en[STB_WE]  = busy && wr_q;
        stb_on[STB_RE]  = on_cfg.re_on;
        stb_off[STB_RE] = on_cfg.re_off;
        stb_en[STB_RE]  = busy && !wr_q;
    end

    for (genvar g = 0; g < NSTROBE; g++) begin : g_win
        pbus_window #(.ON_W(ON_W), .OFF_W(OFF_W), .T_W(TICK_W)) u_win (
            .en     (stb_en[g]),
            .on     (stb_on[g]),
            .off    (stb_off[g]),
            .tick   (tick_w),
            .active (stb_act[g])
        );
    end

    for (genvar c = 0; c < NCS; c++) begin : g_cs
        pol_t pc;
        assign pc        = pol_t'(pol[c]);
        assign cs_pin[c] = (stb_act[STB_CS] && (tgt_q == 1'(c))) ^ !pc.cs;
    end

    assign we_pin     = stb_act[STB_WE] ^ !pol_cfg.we;
    assign re_pin     = stb_act[STB_RE] ^ !pol_cfg.re;
    assign a0_pin     = (busy && a0_q) ^ pol_cfg.a0;
    assign rd_capture = busy && !wr_q && first_w && (tick_w == cy_cfg.acc);
    assign cfg_err    = err_flags(onoff_t'(tim_onoff[cs_sel == SEL_CS1]));

    // R7
    we_re_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stb_act[STB_WE] && stb_act[STB_RE]));

    // R7
    cs_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        stb_act[STB_CS] |-> busy);

    // R4
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R8
    capture_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_capture |=> !rd_capture);
endmodule

// File: tb/pbus_strobe_timer_tb.sv
module pbus_strobe_timer_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]       cs_sel = 2'd0;
    logic [1:0][29:0] oo = '0;
    logic [1:0][27:0] cy = '0;
    logic [1:0]       gx = '0;
    logic [1:0][3:0]  pl = '0;
    logic req_valid = 1'b0, req_write = 1'b0, req_a0 = 1'b0;
    logic busy, we_pin, re_pin, a0_pin, rd_capture, done;
    logic [1:0] cs_pin;
    logic [2:0] cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    int last_t  = 0;

    always #2 clk = ~clk;

    pbus_strobe_timer u_dut (
        .clk(clk), .rst(rst), .cs_sel(cs_sel), .tim_onoff(oo), .tim_cycle(cy),
        .tick_x2(gx), .pol(pl), .req_valid(req_valid), .req_write(req_write),
        .req_a0(req_a0), .busy(busy), .cs_pin(cs_pin), .we_pin(we_pin),
        .re_pin(re_pin), .a0_pin(a0_pin), .rd_capture(rd_capture), .done(done),
        .cfg_err(cfg_err)
    );

    function automatic logic [7:0] obs();
        return {done, busy, cs_pin, we_pin, re_pin, a0_pin, rd_capture};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic bit win(input int on, input int off, input int t);
        return (off > on) && (t >= on) && (t < off);
    endfunction

    function automatic logic [7:0] idle_vec(input logic dn);
        logic [7:0] v;
        v[7] = dn;
        v[6] = 1'b0;
        v[5] = !pl[1][3];
        v[4] = !pl[0][3];
        v[3] = !pl[last_t][2];
        v[2] = !pl[last_t][1];
        v[1] = pl[last_t][0];
        v[0] = 1'b0;
        return v;
    endfunction

    function automatic logic [2:0] exp_err(input int ti);
        logic [2:0] e;
        e[0] = oo[ti][9:4]   <= {2'b0, oo[ti][3:0]};
        e[1] = oo[ti][19:14] <= {2'b0, oo[ti][13:10]};
        e[2] = oo[ti][29:24] <= {2'b0, oo[ti][23:20]};
        return e;
    endfunction

    function automatic logic [7:0] act_vec(input int ti, input bit wr, input bit a0,
                                           input int t, input bit first);
        int cson, csoff, weon, weoff, reon, reoff, pw, acc, csend;
        bit csa, wea, rea;
        logic [7:0] v;
        cson = oo[ti][3:0];   csoff = oo[ti][9:4];
        weon = oo[ti][13:10]; weoff = oo[ti][19:14];
        reon = oo[ti][23:20]; reoff = oo[ti][29:24];
        pw   = cy[ti][17:12]; acc   = cy[ti][27:22];
        csend = (pw != 0 && cson + pw < csoff) ? cson + pw : csoff;
        csa = (csoff > cson) && win(cson, csend, t);
        wea = wr && win(weon, weoff, t);
        rea = !wr && win(reon, reoff, t);
        v[7] = 1'b0;
        v[6] = 1'b1;
        v[5] = (ti == 1) ? (csa ~^ pl[1][3]) : !pl[1][3];
        v[4] = (ti == 0) ? (csa ~^ pl[0][3]) : !pl[0][3];
        v[3] = wea ~^ pl[ti][2];
        v[2] = rea ~^ pl[ti][1];
        v[1] = a0 ^ pl[ti][0];
        v[0] = !wr && first && (t == acc);
        return v;
    endfunction

    // one access on target ti (0 or 1); inj drives a second request mid-access
    task automatic run_acc(input int ti, input bit wr, input bit a0, input bit inj);
        int c, l, n;
        @(negedge clk);
        cs_sel = (ti == 1) ? 2'd2 : 2'd1;
        req_valid = 1'b1; req_write = wr; req_a0 = a0;
        #1;
        chk("R10 cfg_err", {5'b0, cfg_err}, {5'b0, exp_err(ti)});
        @(posedge clk);
        #1 req_valid = 1'b0;
        last_t = ti;
        c = wr ? int'(cy[ti][5:0]) : int'(cy[ti][11:6]);
        if (c == 0) c = 1;
        l = gx[ti] ? 2 : 1;
        n = c * l;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (inj && k == 1) begin req_valid = 1'b1; req_write = !wr; end
            if (inj && k == 2) req_valid = 1'b0;
            chk("R3/R5/R6/R7/R8/R9 active", obs(), act_vec(ti, wr, a0, k / l, (k % l) == 0));
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 done after last busy clock", obs(), idle_vec(1'b1));
        @(negedge clk);
        chk("R2/R4 idle after done", obs(), idle_vec(1'b0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 reset state", obs(), 8'b0_0_11_1_1_0_0);

        // R2: no-target selections are ignored
        oo[0] = {6'd9, 4'd1, 6'd6, 4'd2, 6'd8, 4'd1};
        cy[0] = {6'd3, 4'd0, 6'd0, 6'd10, 6'd10};
        for (int s = 0; s < 4; s += 3) begin
            @(negedge clk);
            cs_sel = 2'(s); req_valid = 1'b1; req_write = 1'b1;
            @(posedge clk);
            #1 req_valid = 1'b0;
            @(negedge clk);
            chk("R2 no target ignored", obs(), idle_vec(1'b0));
            @(negedge clk);
            chk("R2 no target ignored", obs(), idle_vec(1'b0));
        end

        // R5/R7 directed write on CS0
        run_acc(0, 1'b1, 1'b1, 1'b0);
        // R3/R8 read on CS1 with doubled tick
        oo[1] = {6'd7, 4'd2, 6'd4, 4'd1, 6'd9, 4'd0};
        cy[1] = {6'd5, 4'd0, 6'd0, 6'd8, 6'd3};
        gx[1] = 1'b1;
        run_acc(1, 1'b0, 1'b0, 1'b0);
        // R6 pulse-width clip
        cy[0] = {6'd2, 4'd0, 6'd3, 6'd12, 6'd12};
        oo[0] = {6'd9, 4'd1, 6'd6, 4'd2, 6'd20, 4'd1};
        run_acc(0, 1'b1, 1'b0, 1'b0);
        // R3 zero cycle runs one tick
        cy[0] = {6'd0, 4'd0, 6'd0, 6'd0, 6'd0};
        run_acc(0, 1'b0, 1'b1, 1'b0);
        // R10 inverted write window held inactive
        cy[0] = {6'd1, 4'd0, 6'd0, 6'd8, 6'd8};
        oo[0] = {6'd5, 4'd1, 6'd5, 4'd5, 6'd7, 4'd0};
        run_acc(0, 1'b1, 1'b0, 1'b0);
        // R9 all polarities inverted
        pl = {4'hF, 4'hF};
        oo[0] = {6'd6, 4'd1, 6'd5, 4'd1, 6'd7, 4'd0};
        run_acc(0, 1'b0, 1'b1, 1'b0);
        run_acc(0, 1'b1, 1'b0, 1'b0);
        // R2 request during busy is dropped
        pl = '0;
        run_acc(1, 1'b1, 1'b1, 1'b1);

        for (int i = 0; i < 60; i++) begin
            for (int j = 0; j < 2; j++) begin
                oo[j] = 30'($urandom);
                cy[j][5:0]   = 6'($urandom % 18);
                cy[j][11:6]  = 6'($urandom % 18);
                cy[j][17:12] = ($urandom % 3 == 0) ? 6'($urandom % 16) : 6'd0;
                cy[j][21:18] = 4'($urandom);
                cy[j][27:22] = 6'($urandom % 20);
                gx[j] = 1'($urandom);
                pl[j] = 4'($urandom);
            end
            run_acc(int'($urandom % 2), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule